// File: doc/BRIEF.md
# Two-Level Interrupt Enable Controller

This block keeps an 8-bit interrupt control word that software reads and writes. Three of its bits are latched event flags (timer overflow, external edge, port change), three are per-source enables, and the top two are level enables whose meaning depends on a mode input. The block turns the flags, the enables and a vector of peripheral requests into registered request lines for a processor core.

With `prio_mode` low there is a single interrupt level. Bit 7 is the master enable, and bit 6 additionally gates the peripheral requests. With `prio_mode` high every source carries a priority bit. Bit 7 then enables the high level and bit 6 enables the low level, and the low level still needs bit 7. Flags latch whenever their event occurs, even with all enables off, so software can poll them. A hardware set wins over a software clear in the same cycle.

Top module: `irq_ctl_top`

## Requirements
- R1: After reset, `rd_data[7:1]` reads 0, `rd_data[0]` reads the parameter `PC_RST`, and `irq_hi` and `irq_lo` are 0.
- R2: A write (`wr_en` high) loads `wr_data` into the control word. `rd_data` shows the stored word at all times. Enables: bit 7 master/high, bit 6 peripheral/low, bit 5 timer, bit 4 external, bit 3 port change. Flags: bit 2 timer, bit 1 external, bit 0 port change.
- R3: A one-cycle pulse on `tmr_ovf` or `ext_edge`, or a high `port_chg`, sets flag bit 2, 1 or 0 respectively, whatever the value of any enable bit.
- R4: A flag keeps its value until a write puts a new value in its position. A write of 0 clears it and a write of 1 sets it.
- R5: When a set event and a write of 0 hit the same flag in one cycle, the flag ends up set.
- R6: While `port_chg` stays high, flag bit 0 reads 1 after every write that tries to clear it.
- R7: With `prio_mode` low, `irq_hi` = bit7 AND (any of bit2&bit5, bit1&bit4, bit0&bit3, or bit6 AND any `per_req`), and `irq_lo` is 0.
- R8: With `prio_mode` high, `irq_hi` = bit7 AND any high-priority term. The source terms are the flag-and-enable pairs of R7, with `src_hi[0]` for the timer, `src_hi[1]` for the external input and `src_hi[2]` for port change. A peripheral term is `per_req[i]` marked by `per_hi[i]`, and bit 6 does not gate it.
- R9: With `prio_mode` high, `irq_lo` = bit7 AND bit6 AND any term whose priority bit is 0.
- R10: `irq_hi` and `irq_lo` are registered. They reflect the control word and inputs present one clock earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| prio_mode | input | 1 | 1 selects two-level priority operation |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 8 | Value written to the control word |
| rd_data | output | 8 | Current control word |
| tmr_ovf | input | 1 | Timer overflow pulse |
| ext_edge | input | 1 | External edge pulse |
| port_chg | input | 1 | Port mismatch level |
| src_hi | input | 3 | Priority bits of timer, external and port change sources |
| per_req | input | NPER | Peripheral request vector |
| per_hi | input | NPER | Priority bit per peripheral request |
| irq_hi | output | 1 | High-level (or single-level) request |
| irq_lo | output | 1 | Low-level request |

## Verification
A corrupted enable or flag bit shows on `rd_data` in the same cycle it is stored. It also shows on a request output one clock later, once the combination of sources makes that bit decisive. The bench therefore sweeps every control word in both modes against all source priority and peripheral patterns, so each bit is decisive in some combination. A lost set-over-clear priority or a missing port-change re-set shows on the flag read right after the conflicting cycle. A wrong latency shows as a request one cycle early or late.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int CTL_W      = 8;
  localparam int NSRC       = 3;
  localparam int B_MASTER   = 7;
  localparam int B_SECOND   = 6;
  localparam int B_TMR_EN   = 5;
  localparam int B_EXT_EN   = 4;
  localparam int B_PC_EN    = 3;
  localparam int B_TMR_FL   = 2;
  localparam int B_EXT_FL   = 1;
  localparam int B_PC_FL    = 0;
  localparam int EN_LSB     = B_PC_EN;
  localparam int EN_W       = CTL_W - EN_LSB;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/irq_flag_cell.sv
module irq_flag_cell #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic wr_en,
  input  logic wr_val,
  output logic q
);
  logic q_r;
  logic q_d;

  always_comb begin
    q_d = q_r;
    if (wr_en) q_d = wr_val;
    if (set_evt) q_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= RST_VAL;
    else        q_r <= q_d;
  end

  assign q = q_r;

  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_evt && !wr_en) |=> $stable(q_r)) else $error("flag changed without cause"); // R4
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> q_r) else $error("set event lost"); // R5
endmodule

// File: rtl/irq_level_merge.sv
module irq_level_merge #(
  parameter int NSRC = 3,
  parameter int NPER = 2
) (
  input  logic            prio_mode,
  input  logic            master_en,
  input  logic            second_en,
  input  logic [NSRC-1:0] src_term,
  input  logic [NSRC-1:0] src_hi,
  input  logic [NPER-1:0] per_req,
  input  logic [NPER-1:0] per_hi,
  output logic            req_hi_d,
  output logic            req_lo_d
);
  logic any_src;
  logic any_per;
  logic hi_terms;
  logic lo_terms;

  always_comb begin
    any_src  = |src_term;
    any_per  = |per_req;
    hi_terms = |(src_term & src_hi)  | |(per_req & per_hi);
    lo_terms = |(src_term & ~src_hi) | |(per_req & ~per_hi);
    if (prio_mode) begin
      req_hi_d = master_en & hi_terms;
      req_lo_d = master_en & second_en & lo_terms;
    end else begin
      req_hi_d = master_en & (any_src | (second_en & any_per));
      req_lo_d = 1'b0;
    end
  end
endmodule

// File: rtl/irq_ctl_top.sv
module irq_ctl_top
  import irq_pkg::*;
#(
  parameter int   NPER   = 2,
  parameter logic PC_RST = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             prio_mode,
  input  logic             wr_en,
  input  logic [CTL_W-1:0] wr_data,
  output logic [CTL_W-1:0] rd_data,
  input  logic             tmr_ovf,
  input  logic             ext_edge,
  input  logic             port_chg,
  input  logic [NSRC-1:0]  src_hi,
  input  logic [NPER-1:0]  per_req,
  input  logic [NPER-1:0]  per_hi,
  output logic             irq_hi,
  output logic             irq_lo
);
  logic            rst_sync_n;
  logic [EN_W-1:0] en_q;
  logic [EN_W-1:0] en_d;
  logic [NSRC-1:0] set_vec;
  logic [NSRC-1:0] flag_q;
  logic [NSRC-1:0] en_src;
  logic [NSRC-1:0] src_term;
  logic            req_hi_d;
  logic            req_lo_d;
  logic            irq_hi_q;
  logic            irq_lo_q;

  irq_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // enable bits: written only by software
  always_comb begin
    en_d = en_q;
    if (wr_en) en_d = wr_data[CTL_W-1:EN_LSB];
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) en_q <= '0;
    else             en_q <= en_d;
  end

  // flag bits: index 2 timer, 1 external, 0 port change
  assign set_vec = {tmr_ovf, ext_edge, port_chg};

  for (genvar g = 0; g < NSRC; g++) begin : g_flag
    localparam logic RV = (g == B_PC_FL) ? PC_RST : 1'b0;
    irq_flag_cell #(.RST_VAL(RV)) u_cell (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .set_evt (set_vec[g]),
      .wr_en   (wr_en),
      .wr_val  (wr_data[g]),
      .q       (flag_q[g])
    );
  end

  // per-source enables aligned to the flag order
  assign en_src   = {en_q[B_TMR_EN-EN_LSB], en_q[B_EXT_EN-EN_LSB], en_q[B_PC_EN-EN_LSB]};
  // src_hi is ordered timer=0, external=1, port=2; reorder terms to match
  assign src_term = {flag_q[B_PC_FL]  & en_src[B_PC_FL],
                     flag_q[B_EXT_FL] & en_src[B_EXT_FL],
                     flag_q[B_TMR_FL] & en_src[B_TMR_FL]};

  irq_level_merge #(.NSRC(NSRC), .NPER(NPER)) u_merge (
    .prio_mode (prio_mode),
    .master_en (en_q[B_MASTER-EN_LSB]),
    .second_en (en_q[B_SECOND-EN_LSB]),
    .src_term  (src_term),
    .src_hi    (src_hi),
    .per_req   (per_req),
    .per_hi    (per_hi),
    .req_hi_d  (req_hi_d),
    .req_lo_d  (req_lo_d)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      irq_hi_q <= 1'b0;
      irq_lo_q <= 1'b0;
    end else begin
      irq_hi_q <= req_hi_d;
      irq_lo_q <= req_lo_d;
    end
  end

  assign rd_data = {en_q, flag_q};
  assign irq_hi  = irq_hi_q;
  assign irq_lo  = irq_lo_q;

  AST_FLAT_NO_LO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !prio_mode |=> !irq_lo) else $error("low request in flat mode"); // R7
  AST_MASTER_GATE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !rd_data[B_MASTER] |=> (!irq_hi && !irq_lo)) else $error("request with master off"); // R8
  AST_LO_NEEDS_SECOND: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !rd_data[B_SECOND] |=> !irq_lo) else $error("low request with bit 6 off"); // R9
  AST_TMR_LATCH: assert property (@(posedge clk) disable iff (!rst_sync_n)
    tmr_ovf |=> rd_data[B_TMR_FL]) else $error("timer flag not latched"); // R3
  AST_PC_PERSIST: assert property (@(posedge clk) disable iff (!rst_sync_n)
    port_chg |=> rd_data[B_PC_FL]) else $error("port flag cleared during mismatch"); // R6
endmodule

// File: tb/tb_irq_ctl_top.sv
`timescale 1ns/1ps
module tb_irq_ctl_top;
  localparam int NPER = 2;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            prio_mode;
  logic            wr_en;
  logic [7:0]      wr_data;
  logic [7:0]      rd_data;
  logic            tmr_ovf, ext_edge, port_chg;
  logic [2:0]      src_hi;
  logic [NPER-1:0] per_req, per_hi;
  logic            irq_hi, irq_lo;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  irq_ctl_top #(.NPER(NPER), .PC_RST(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .prio_mode(prio_mode), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .tmr_ovf(tmr_ovf),
    .ext_edge(ext_edge), .port_chg(port_chg), .src_hi(src_hi),
    .per_req(per_req), .per_hi(per_hi), .irq_hi(irq_hi), .irq_lo(irq_lo)
  );

  always #5 clk = ~clk;

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_ctl(input logic [7:0] v);
    wr_en = 1'b1; wr_data = v;
    cyc(1);
    wr_en = 1'b0;
  endtask

  function automatic logic [1:0] model(input logic m, input logic [7:0] v,
                                       input logic [2:0] h, input logic [1:0] p,
                                       input logic [1:0] ph);
    logic [2:0] t;
    logic hi, lo;
    t[0] = v[2] & v[5];
    t[1] = v[1] & v[4];
    t[2] = v[0] & v[3];
    if (!m) begin
      hi = v[7] & ((|t) | (v[6] & (|p)));
      lo = 1'b0;
    end else begin
      hi = v[7] & ((|(t & h)) | (|(p & ph)));
      lo = v[7] & v[6] & ((|(t & ~h)) | (|(p & ~ph)));
    end
    return {hi, lo};
  endfunction

  initial begin : watchdog
    int n = 0;
    while (!done) begin
      @(posedge clk);
      n++;
      if (n > 150000) begin
        bad++; total++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    rst_n = 1'b0; prio_mode = 0; wr_en = 0; wr_data = 0;
    tmr_ovf = 0; ext_edge = 0; port_chg = 0; src_hi = 0; per_req = 0; per_hi = 0;
    cyc(3);
    rst_n = 1'b1;
    cyc(3);
    // R1 reset state
    check("R1 ctl", rd_data, 8'h00);
    check("R1 irq", {6'd0, irq_hi, irq_lo}, 8'h00);

    // R3 flags latch with every enable off
    tmr_ovf = 1; cyc(1); tmr_ovf = 0;
    check("R3 timer flag", rd_data, 8'h04);
    ext_edge = 1; cyc(1); ext_edge = 0;
    port_chg = 1; cyc(1); port_chg = 0;
    check("R3 all flags", rd_data, 8'h07);
    cyc(1);
    check("R3 no request", {6'd0, irq_hi, irq_lo}, 8'h00);

    // R4 flags hold, clear by writing 0, set by writing 1
    cyc(4);
    check("R4 hold", rd_data, 8'h07);
    write_ctl(8'h05);
    check("R4 clear ext", rd_data, 8'h05);
    write_ctl(8'h00);
    check("R4 clear all", rd_data, 8'h00);
    write_ctl(8'h02);
    check("R4 write one", rd_data, 8'h02);
    write_ctl(8'h00);

    // R5 set beats clear in the same cycle
    tmr_ovf = 1; wr_en = 1; wr_data = 8'h00; cyc(1);
    tmr_ovf = 0; wr_en = 0;
    check("R5 set wins", rd_data, 8'h04);
    write_ctl(8'h00);

    // R6 port-change flag persists while mismatch holds
    port_chg = 1;
    for (int i = 0; i < 3; i++) begin
      write_ctl(8'h00);
      check("R6 persist", rd_data, 8'h01);
    end
    port_chg = 0; cyc(1);
    write_ctl(8'h00);
    check("R6 clear after release", rd_data, 8'h00);

    // R10 one-cycle registered latency
    cyc(2);
    write_ctl(8'hA4);
    check("R10 not early", {7'd0, irq_hi}, 8'h00);
    cyc(1);
    check("R10 one cycle later", {7'd0, irq_hi}, 8'h01);
    write_ctl(8'h00);
    cyc(1);

    // R2 R7 R8 R9 sweep: both modes, every word, all priority/request patterns
    for (int m = 0; m < 2; m++) begin
      for (int v = 0; v < 256; v++) begin
        for (int h = 0; h < 8; h++) begin
          for (int p = 0; p < 4; p++) begin
            logic [1:0] e;
            prio_mode = m[0]; src_hi = h[2:0]; per_req = p[1:0]; per_hi = h[2:1];
            write_ctl(v[7:0]);
            check("R2 readback", rd_data, v[7:0]);
            cyc(1);
            e = model(m[0], v[7:0], h[2:0], p[1:0], h[2:1]);
            if (m == 0) check("R7 flat request", {6'd0, irq_hi, irq_lo}, {6'd0, e});
            else begin
              check("R8 high request", {7'd0, irq_hi}, {7'd0, e[1]});
              check("R9 low request",  {7'd0, irq_lo}, {7'd0, e[0]});
            end
          end
        end
      end
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule